// File: doc/BRIEF.md
# Vectored Interrupt Controller with Two-Pulse Acknowledge

This block gathers interrupt requests from eight devices and turns them into one interrupt signal for a processor. A request is captured on the rising edge of its input line and stays pending until the processor takes its vector. Each line has its own mask bit. Among the lines that are both pending and unmasked, the one with the lowest index wins.

The processor answers the interrupt with two active-low acknowledge pulses. The first pulse withdraws the interrupt output. During the second pulse the controller picks a line again from the state at that moment. It places `base | line` on an 8-bit data output and raises the output-enable, then clears that line's pending bit. If no unmasked line is left by then, it delivers a spurious vector, `base | 7`, and clears nothing. A small write port loads the mask register and the vector base register.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A request is captured when its input is sampled high after being sampled low on the previous clock. A line held high captures one request only and does not capture again until it has gone low.
- R2: The mask register resets to all zeros, so every line is enabled. A write with `wr_sel`=0 loads `wr_data[7:0]` into it, and bit i set to 1 masks line i. A line that is pending but masked never raises `int_o`.
- R3: When several unmasked lines are pending, line 0 has the highest priority and line 7 the lowest.
- R4: The delivered vector is `base | line`. The base resets to 32. A write with `wr_sel`=1 loads `wr_data` with bits [2:0] forced to zero.
- R5: `int_o` rises one clock after an idle controller sees an unmasked pending line. It falls one clock after `inta_n` is first sampled low. `vec_oe` rises one clock after the second low sample of `inta_n` and falls one clock after `inta_n` is sampled high again. `int_o` and `vec_oe` are never high together.
- R6: A pending request is held until its vector is delivered, and delivery clears it. If every pending line becomes masked before the first pulse, `int_o` falls and the controller returns to idle with the requests still pending.
- R7: The line is chosen again at the second pulse. If the first choice has been masked, the next unmasked pending line is delivered. If none is left, the vector is `base | 7` and no pending bit is cleared.
- R8: After reset, `int_o` and `vec_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Device request lines, captured on their rising edge |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the mask, 1 selects the base |
| wr_data | input | 8 | Write data |
| inta_n | input | 1 | Active-low acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector value, valid while `vec_oe` is high |
| vec_oe | output | 1 | Data bus drive enable; low means the bus is released |

## Verification
The hardest cases occur in the gap between the two acknowledge pulses, when the mask changes after the first pulse has already withdrawn the interrupt. The bench splits the handshake into separate first-pulse and second-pulse steps and writes the mask register between them. This forces the second pulse to choose the next line down, or to find nothing and return the spurious vector. In both cases the bench then shows through `int_o` which requests are still pending.

// File: rtl/vic_pkg.sv
package vic_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_ACK1  = 3'd2,
      ST_GAP   = 3'd3,
      ST_DRIVE = 3'd4
   } ack_state_e;
endpackage

// File: rtl/vic_req_latch.sv
module vic_req_latch #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_i,
   input  logic [LINES-1:0] clr_i,
   output logic [LINES-1:0] pend_o
);
   logic [LINES-1:0] req_q;
   logic [LINES-1:0] rise;

   assign rise = req_i & ~req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         pend_o <= '0;
      end else begin
         req_q  <= req_i;
         pend_o <= (pend_o & ~clr_i) | rise;
      end
   end

   // R6: only a pending line may be cleared by a delivery
   assert_clear_hits_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~pend_o) == '0));
   // R1: a line newly pending must have risen on the previous sample
   assert_capture_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i == '0) |=> ((pend_o & ~$past(pend_o) & ~$past(req_i & ~req_q)) == '0)));
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
   parameter int LINES = 8,
   localparam int IW   = $clog2(LINES)
) (
   input  logic [LINES-1:0] cand_i,
   output logic [LINES-1:0] grant_o,
   output logic [IW-1:0]    idx_o,
   output logic             any_o
);
   logic [LINES:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar g = 0; g < LINES; g++) begin : g_chain
      assign grant_o[g]   = cand_i[g] & ~blocked[g];
      assign blocked[g+1] = blocked[g] | cand_i[g];
   end

   assign any_o = blocked[LINES];

   always_comb begin
      idx_o = '0;
      for (int k = 0; k < LINES; k++) begin
         if (grant_o[k]) idx_o = IW'(k);
      end
   end

   // R3: at most one line wins
   always_comb begin
      assert_single_grant_R3: assert ($onehot0(grant_o));
   end
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm
   import vic_pkg::*;
#(
   parameter int LINES = 8,
   parameter int VW    = 8,
   localparam int IW   = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inta_n_i,
   input  logic             any_i,
   input  logic [IW-1:0]    idx_i,
   input  logic [LINES-1:0] grant_i,
   input  logic [VW-IW-1:0] base_hi_i,
   output logic [LINES-1:0] clr_o,
   output logic             int_o,
   output logic [VW-1:0]    vec_o,
   output logic             oe_o
);
   ack_state_e state;
   logic       inta_q;
   logic       ack_fall;
   logic       ack_rise;
   logic       deliver;

   assign ack_fall = inta_q & ~inta_n_i;
   assign ack_rise = ~inta_q & inta_n_i;
   assign deliver  = (state == ST_GAP) && ack_fall;
   assign clr_o    = deliver ? grant_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         inta_q <= 1'b1;
         int_o  <= 1'b0;
         oe_o   <= 1'b0;
         vec_o  <= '0;
      end else begin
         inta_q <= inta_n_i;
         unique case (state)
            ST_IDLE: if (any_i) begin
               int_o <= 1'b1;
               state <= ST_ARMED;
            end
            ST_ARMED: if (ack_fall) begin
               int_o <= 1'b0;
               state <= ST_ACK1;
            end else if (!any_i) begin
               int_o <= 1'b0;
               state <= ST_IDLE;
            end
            ST_ACK1: if (ack_rise) state <= ST_GAP;
            ST_GAP: if (deliver) begin
               vec_o <= any_i ? {base_hi_i, idx_i} : {base_hi_i, {IW{1'b1}}};
               oe_o  <= 1'b1;
               state <= ST_DRIVE;
            end
            ST_DRIVE: if (ack_rise) begin
               oe_o  <= 1'b0;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: with nothing unmasked pending, an idle controller stays quiet
   assert_no_cause_no_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && !any_i) |=> !int_o);
   // R5: interrupt and bus drive never overlap
   assert_int_oe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_o && oe_o));
   // R5: bus drive only follows a low acknowledge sample
   assert_oe_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> $past(!inta_n_i));
   // R5: interrupt drops after the first low acknowledge sample
   assert_int_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_o && ack_fall) |=> !int_o);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int LINES    = 8,
   parameter int VW       = 8,
   parameter int BASE_RST = 32,
   localparam int IW      = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] irq_req,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [VW-1:0]    wr_data,
   input  logic             inta_n,
   output logic             int_o,
   output logic [VW-1:0]    vec_o,
   output logic             vec_oe
);
   if (LINES < 2 || (1 << IW) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (VW <= IW || VW < LINES) begin : g_bad_width
      $error("VW must hold the line index and the mask");
   end
   if ((BASE_RST % LINES) != 0 || BASE_RST >= (1 << VW)) begin : g_bad_base
      $error("BASE_RST must be aligned to LINES and fit in VW bits");
   end

   logic [LINES-1:0] mask_q;
   logic [VW-IW-1:0] base_hi_q;
   logic [LINES-1:0] pend;
   logic [LINES-1:0] clr;
   logic [LINES-1:0] grant;
   logic [IW-1:0]    idx;
   logic             any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         base_hi_q <= (VW-IW)'(BASE_RST >> IW);
      end else if (wr_en) begin
         if (wr_sel) base_hi_q <= wr_data[VW-1:IW];
         else        mask_q    <= wr_data[LINES-1:0];
      end
   end

   vic_req_latch #(.LINES(LINES)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (irq_req),
      .clr_i  (clr),
      .pend_o (pend)
   );

   vic_prio_pick #(.LINES(LINES)) u_pick (
      .cand_i  (pend & ~mask_q),
      .grant_o (grant),
      .idx_o   (idx),
      .any_o   (any)
   );

   vic_ack_fsm #(.LINES(LINES), .VW(VW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .inta_n_i  (inta_n),
      .any_i     (any),
      .idx_i     (idx),
      .grant_i   (grant),
      .base_hi_i (base_hi_q),
      .clr_o     (clr),
      .int_o     (int_o),
      .vec_o     (vec_o),
      .oe_o      (vec_oe)
   );

   // R2: a delivered line was unmasked when chosen
   assert_clear_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & mask_q) == '0));
endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       inta_n = 1'b1;
   logic       int_o;
   logic [7:0] vec_o;
   logic       vec_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   vec_irq_ctrl i_vec_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .inta_n(inta_n),
      .int_o(int_o), .vec_o(vec_o), .vec_oe(vec_oe)
   );

   // behavioural reference model
   int m_st;
   int m_req_q, m_pend, m_mask, m_base, m_inta_q;
   bit m_int, m_oe;
   int m_vec;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_req_q = 0; m_pend = 0; m_mask = 0; m_base = 32;
         m_inta_q = 1; m_int = 0; m_oe = 0; m_vec = 0;
      end else begin
         int rise, cand, clr, pick;
         bit fall, up;
         rise = irq_req & ~m_req_q & 8'hFF;
         cand = m_pend & ~m_mask & 8'hFF;
         fall = (m_inta_q == 1) && (inta_n == 0);
         up   = (m_inta_q == 0) && (inta_n == 1);
         clr  = 0;
         pick = -1;
         for (int i = 7; i >= 0; i--) if (cand[i]) pick = i;
         case (m_st)
            0: if (cand != 0) begin m_int = 1; m_st = 1; end
            1: if (fall) begin m_int = 0; m_st = 2; end
               else if (cand == 0) begin m_int = 0; m_st = 0; end
            2: if (up) m_st = 3;
            3: if (fall) begin
                  if (pick >= 0) begin m_vec = m_base + pick; clr = 1 << pick; end
                  else m_vec = m_base + 7;
                  m_oe = 1; m_st = 4;
               end
            4: if (up) begin m_oe = 0; m_st = 0; end
            default: m_st = 0;
         endcase
         m_pend = ((m_pend & ~clr) | rise) & 8'hFF;
         if (wr_en) begin
            if (wr_sel) m_base = wr_data & 8'hF8;
            else        m_mask = wr_data;
         end
         m_req_q = irq_req;
         m_inta_q = inta_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (int_o !== m_int) begin
            errors++;
            $display("FAIL R5 int_o act=%0b exp=%0b t=%0t", int_o, m_int, $time);
         end
         checks++;
         if (vec_oe !== m_oe) begin
            errors++;
            $display("FAIL R5 vec_oe act=%0b exp=%0b t=%0t", vec_oe, m_oe, $time);
         end
         if (m_oe) begin
            checks++;
            if (vec_o !== m_vec[7:0]) begin
               errors++;
               $display("FAIL R4 vec_o act=%0d exp=%0d t=%0t", vec_o, m_vec, $time);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [7:0] lines);
      @(negedge clk); irq_req = irq_req | lines;
      @(negedge clk); irq_req = irq_req & ~lines;
   endtask

   task automatic wreg(input bit sel, input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic wait_int(input string tag);
      int n = 0;
      while (!int_o && n < 20) begin @(negedge clk); n++; end
      chk(int_o === 1'b1, tag, int_o, 1);
   endtask

   task automatic ack_first();
      @(negedge clk); inta_n = 0;
      repeat (2) @(negedge clk);
      inta_n = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic ack_second(output int got);
      got = -1;
      inta_n = 0;
      repeat (3) begin @(negedge clk); if (vec_oe) got = vec_o; end
      inta_n = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic ack_full(output int got);
      ack_first();
      ack_second(got);
   endtask

   initial begin
      int v;
      repeat (3) @(negedge clk);
      chk(int_o === 1'b0 && vec_oe === 1'b0, "R8 reset outputs", {int_o, vec_oe}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // single one-cycle request held pending until acknowledged
      pulse(8'h08);
      repeat (6) @(negedge clk);
      chk(int_o === 1'b1, "R6 pending held", int_o, 1);
      ack_full(v);
      chk(v == 35, "R4 vector line3", v, 35);

      // level held high captures once
      @(negedge clk); irq_req[4] = 1;
      wait_int("R1 int for held line");
      ack_full(v);
      chk(v == 36, "R1 vector line4", v, 36);
      repeat (6) @(negedge clk);
      chk(int_o === 1'b0, "R1 no retrigger on held level", int_o, 0);
      @(negedge clk); irq_req[4] = 0;

      // simultaneous requests: priority
      pulse(8'h24);
      wait_int("R3 int for pair");
      ack_full(v);
      chk(v == 34, "R3 line2 before line5", v, 34);
      wait_int("R6 second of pair");
      ack_full(v);
      chk(v == 37, "R3 line5 next", v, 37);

      // masking
      wreg(0, 8'h02);
      pulse(8'h02);
      repeat (6) @(negedge clk);
      chk(int_o === 1'b0, "R2 masked line silent", int_o, 0);
      wreg(0, 8'h00);
      wait_int("R6 unmask raises int");
      ack_full(v);
      chk(v == 33, "R2 vector after unmask", v, 33);

      // re-selection at second pulse
      pulse(8'h41);
      wait_int("R7 int for lines 0,6");
      ack_first();
      wreg(0, 8'h01);
      ack_second(v);
      chk(v == 38, "R7 next line after mask", v, 38);
      repeat (4) @(negedge clk);
      chk(int_o === 1'b0, "R2 masked line0 stays silent", int_o, 0);
      wreg(0, 8'h00);
      wait_int("R7 line0 still pending");
      ack_full(v);
      chk(v == 32, "R7 line0 delivered", v, 32);

      // spurious vector
      pulse(8'h04);
      wait_int("R7 int for line2");
      ack_first();
      wreg(0, 8'hFF);
      ack_second(v);
      chk(v == 39, "R7 spurious vector", v, 39);
      wreg(0, 8'h00);
      wait_int("R7 spurious cleared nothing");
      ack_full(v);
      chk(v == 34, "R7 line2 after spurious", v, 34);

      // base register with low bits forced
      wreg(1, 8'h4F);
      pulse(8'h01);
      wait_int("R4 int with new base");
      ack_full(v);
      chk(v == 8'h48, "R4 base low bits zero", v, 8'h48);

      // withdrawal before first pulse
      pulse(8'h20);
      wait_int("R6 int before withdraw");
      wreg(0, 8'h20);
      repeat (3) @(negedge clk);
      chk(int_o === 1'b0, "R6 int withdrawn", int_o, 0);
      wreg(0, 8'h00);
      wait_int("R6 withdrawn still pending");
      ack_full(v);
      chk(v == 8'h4D, "R6 vector after withdraw", v, 8'h4D);

      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired act=1 exp=0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule